// File: doc/BRIEF.md
# Address-Compressing Request Frame Encoder

The encoder turns a read or write request for 1, 2 or 4 bytes into the bit frame that a serial link master sends to one of four targets. A target is chosen by a 2-bit ID, and its space is reached by a 21-bit address. To shorten frames, the block remembers the word last reached with success. It sends a 2-bit same-word form, a 9-bit signed offset form or a full 21-bit form, whichever is the shortest that applies. A 4-bit CRC is appended to every frame. The block also builds the fixed data-poll, error-poll and terminate frames.

A request is presented for one cycle. The frame appears, right-aligned with its bit count, one cycle later. The serialiser that sends it and the logic that parses the response are outside the block. That logic reports each outcome on `done_i`/`done_ok_i`, and the block uses it to keep or drop the remembered word. A line break request, given on `break_i`, also drops it.

Top module: `addr_cmp_frame_enc`

## Requirements
- R1: `frame_o` holds the frame right-aligned, with the first bit sent at bit `frame_bits_o-1`. Every bit above the count is 0. An access frame is built in this order: ID (2 bits), then opcode, then a direction bit (1 = read, 0 = write), then the address field, then the size bit, then for writes the data bytes with `req_wdata_i[7:0]` first, then the CRC.
- R2: When the remembered word is valid, its ID equals `req_id_i` and its word equals `req_addr_i[20:2]`, the opcode is 2'b11 and the address field is 2 bits wide, holding `req_addr_i[1:0]`.
- R3: When R2 does not apply, the remembered word is valid with the same ID, and `req_addr_i - {word,2'b00}` lies in -256..+255, the opcode is 3'b101 and the address field is that offset in 9-bit two's complement.
- R4: In every other case, including when the remembered word is invalid, the opcode is 3'b100 and the address field is the 21-bit address.
- R5: `req_size_i` gives the transfer size: 0 means 1 byte, with size bit 0. 1 means 2 bytes, with the address field's bit 0 forced to 0 and size bit 1. 2 or 3 means 4 bytes, with field bits [1:0] forced to 2'b01 and size bit 1. A write carries that many data bytes.
- R6: `req_kind_i` selects the frame type: 0 = access, 1 = data poll (ID followed by 3'b010), 2 = error poll (ID followed by 3'b011), 3 = terminate (ID followed by 6'b111111). Each is followed by the CRC.
- R7: The 4-bit CRC uses x^4+x+1 and starts at 0. It first takes a 1 bit and then takes every frame bit before the CRC, first-sent first.
- R8: A successful outcome for an access stores {ID, addr[20:2]} as valid. A failed outcome for an access, or any outcome for a terminate, invalidates it. Outcomes for polls change nothing.
- R9: Reset or `break_i` invalidates the remembered word.
- R10: `frame_valid_o` is high exactly in the cycle after each cycle with `req_valid_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Build a frame from the request fields |
| req_kind_i | input | 2 | Frame type (R6) |
| req_write_i | input | 1 | 1 = write access |
| req_id_i | input | 2 | Target ID |
| req_addr_i | input | 21 | Byte address |
| req_size_i | input | 2 | Transfer size code (R5) |
| req_wdata_i | input | 32 | Write bytes, the lowest byte sent first |
| done_i | input | 1 | Outcome strobe for the last frame |
| done_ok_i | input | 1 | Outcome was a success |
| break_i | input | 1 | Line break issued; drop the remembered word |
| frame_valid_o | output | 1 | Frame output is new this cycle |
| frame_o | output | 64 | Frame bits, right-aligned |
| frame_bits_o | output | 7 | Number of frame bits |

## Verification
A wrong remembered word does not show at once. It shows on the next access to the same target, as a wrong opcode and a wrong frame length (12, 20 or 32 bits plus data) in the cycle after the request. The bench therefore follows each outcome, break and reset with an access whose encoding depends on that event. The ±256 offset edges, an outcome for a poll and a change of ID are placed in the same way. A wrong CRC or field packing shows in the first frame that uses the path.

// File: rtl/frame_enc_pkg.sv
package frame_enc_pkg;
  typedef enum logic [1:0] {
    KIND_ACCESS = 2'd0,
    KIND_DPOLL  = 2'd1,
    KIND_EPOLL  = 2'd2,
    KIND_TERM   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    AM_ABS  = 2'd0,
    AM_REL  = 2'd1,
    AM_SAME = 2'd2
  } addr_mode_e;

  // one serial step of x^4+x+1
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
  endfunction
endpackage

// File: rtl/last_addr_trk.sv
module last_addr_trk #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [ID_W-1:0]   id_o,
  output logic [ADDR_W-3:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      id_o    <= '0;
      word_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      id_o    <= id_i;
      word_o  <= addr_i[ADDR_W-1:2];
    end
  end

  // R9
  clr_invalidates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);

  // R8
  set_stores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> (valid_o && id_o == $past(id_i)
                           && word_o == $past(addr_i[ADDR_W-1:2])));
endmodule

// File: rtl/addr_mode_sel.sv
module addr_mode_sel
  import frame_enc_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 21,
  parameter int REL_W  = 9
) (
  input  logic              lv_valid_i,
  input  logic [ID_W-1:0]   lv_id_i,
  input  logic [ADDR_W-3:0] lv_word_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  output addr_mode_e        mode_o,
  output logic [ADDR_W-1:0] field_o
);
  logic [ADDR_W:0]        diff;
  logic [ADDR_W-REL_W+1:0] diff_top;
  logic                   id_hit, in_rng;

  assign diff     = {1'b0, addr_i} - {1'b0, lv_word_i, 2'b00};
  assign diff_top = diff[ADDR_W:REL_W-1];
  // offset fits when the sign-extension bits are uniform
  assign in_rng   = (&diff_top) | ~(|diff_top);
  assign id_hit   = lv_valid_i && (lv_id_i == id_i);

  always_comb begin
    if (id_hit && lv_word_i == addr_i[ADDR_W-1:2]) begin
      mode_o  = AM_SAME;
      field_o = {{(ADDR_W-2){1'b0}}, addr_i[1:0]};
    end else if (id_hit && in_rng) begin
      mode_o  = AM_REL;
      field_o = {{(ADDR_W-REL_W){1'b0}}, diff[REL_W-1:0]};
    end else begin
      mode_o  = AM_ABS;
      field_o = addr_i;
    end
  end
endmodule

// File: rtl/frame_pack.sv
module frame_pack
  import frame_enc_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 21,
  parameter int REL_W   = 9,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 64,
  parameter int CNT_W   = 7
) (
  input  req_kind_e          kind_i,
  input  logic               write_i,
  input  logic [ID_W-1:0]    id_i,
  input  addr_mode_e         mode_i,
  input  logic [ADDR_W-1:0]  field_i,
  input  logic [1:0]         size_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   bits_o
);
  localparam int NB = DATA_W / 8;

  function automatic logic [FRAME_W-1:0] app(input logic [FRAME_W-1:0] f,
                                             input logic [FRAME_W-1:0] v,
                                             input int w);
    return (f << w) | (v & ((FRAME_W'(1) << w) - FRAME_W'(1)));
  endfunction

  logic [FRAME_W-1:0] f;
  logic [ADDR_W-1:0]  fld;
  logic [2:0]         op;
  logic [3:0]         crc;
  logic               ds;
  int                 n, ow, aw, nb;

  always_comb begin
    f   = '0;
    n   = 0;
    fld = field_i;
    op  = '0;
    ow  = 0;
    aw  = 0;
    crc = '0;
    case (size_i)
      2'd0:    begin nb = 1; ds = 1'b0; end
      2'd1:    begin nb = 2; ds = 1'b1; fld[0] = 1'b0; end
      default: begin nb = 4; ds = 1'b1; fld[1:0] = 2'b01; end
    endcase
    case (mode_i)
      AM_SAME: begin op = 3'b011; ow = 2; aw = 2;      end
      AM_REL:  begin op = 3'b101; ow = 3; aw = REL_W;  end
      default: begin op = 3'b100; ow = 3; aw = ADDR_W; end
    endcase

    f = app(f, FRAME_W'(id_i), ID_W);
    n = n + ID_W;
    case (kind_i)
      KIND_ACCESS: begin
        f = app(f, FRAME_W'(op), ow);
        f = app(f, FRAME_W'(!write_i), 1);
        f = app(f, FRAME_W'(fld), aw);
        f = app(f, FRAME_W'(ds), 1);
        n = n + ow + aw + 2;
        for (int i = 0; i < NB; i++) begin
          if (write_i && i < nb) begin
            f = app(f, FRAME_W'(wdata_i[8*i +: 8]), 8);
            n = n + 8;
          end
        end
      end
      KIND_DPOLL: begin f = app(f, FRAME_W'(3'b010), 3); n = n + 3; end
      KIND_EPOLL: begin f = app(f, FRAME_W'(3'b011), 3); n = n + 3; end
      default:    begin f = app(f, FRAME_W'(6'h3f), 6);  n = n + 6; end
    endcase

    // implicit start bit, then frame bits first-sent first
    crc = crc4_step(crc, 1'b1);
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      if (i < n) crc = crc4_step(crc, f[i]);
    end
    f = app(f, FRAME_W'(crc), 4);
    n = n + 4;
  end

  assign frame_o = f;
  assign bits_o  = CNT_W'(n);
endmodule

// File: rtl/addr_cmp_frame_enc.sv
module addr_cmp_frame_enc
  import frame_enc_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 21,
  parameter int REL_W   = 9,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 64,
  parameter int CNT_W   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_kind_i,
  input  logic               req_write_i,
  input  logic [ID_W-1:0]    req_id_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic               done_i,
  input  logic               done_ok_i,
  input  logic               break_i,
  output logic               frame_valid_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   frame_bits_o
);
  logic              lv_valid;
  logic [ID_W-1:0]   lv_id;
  logic [ADDR_W-3:0] lv_word;
  addr_mode_e        mode;
  logic [ADDR_W-1:0] field;
  logic [FRAME_W-1:0] frame_d;
  logic [CNT_W-1:0]  bits_d;
  req_kind_e         kind_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic              lv_set, lv_clr;

  // outcome applies to the last issued frame
  assign lv_set = done_i && done_ok_i && kind_q == KIND_ACCESS;
  assign lv_clr = break_i ||
                  (done_i && ((kind_q == KIND_ACCESS && !done_ok_i) || kind_q == KIND_TERM));

  last_addr_trk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) trk_i (
    .clk_i, .rst_ni,
    .set_i(lv_set), .clr_i(lv_clr), .id_i(id_q), .addr_i(addr_q),
    .valid_o(lv_valid), .id_o(lv_id), .word_o(lv_word)
  );

  addr_mode_sel #(.ID_W(ID_W), .ADDR_W(ADDR_W), .REL_W(REL_W)) sel_i (
    .lv_valid_i(lv_valid), .lv_id_i(lv_id), .lv_word_i(lv_word),
    .id_i(req_id_i), .addr_i(req_addr_i), .mode_o(mode), .field_o(field)
  );

  frame_pack #(.ID_W(ID_W), .ADDR_W(ADDR_W), .REL_W(REL_W), .DATA_W(DATA_W),
               .FRAME_W(FRAME_W), .CNT_W(CNT_W)) pack_i (
    .kind_i(req_kind_e'(req_kind_i)), .write_i(req_write_i), .id_i(req_id_i),
    .mode_i(mode), .field_i(field), .size_i(req_size_i), .wdata_i(req_wdata_i),
    .frame_o(frame_d), .bits_o(bits_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_valid_o <= 1'b0;
      frame_o       <= '0;
      frame_bits_o  <= '0;
      kind_q        <= KIND_DPOLL;
      id_q          <= '0;
      addr_q        <= '0;
    end else begin
      frame_valid_o <= req_valid_i;
      if (req_valid_i) begin
        frame_o      <= frame_d;
        frame_bits_o <= bits_d;
        kind_q       <= req_kind_e'(req_kind_i);
        id_q         <= req_id_i;
        addr_q       <= req_addr_i;
      end
    end
  end

  // R10
  req_to_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> frame_valid_o);

  // R10
  no_spurious_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !frame_valid_o);

  // R1
  frame_tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> ((frame_o >> frame_bits_o) == '0));

  // R6
  frame_len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> (frame_bits_o >= 7'd9 && 32'(frame_bits_o) <= FRAME_W));
endmodule

// File: tb/addr_cmp_frame_enc_tb_top.sv
module addr_cmp_frame_enc_tb_top;
  typedef struct packed {
    logic [1:0]  kind;
    logic        wr;
    logic [1:0]  id;
    logic [20:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [1:0]  outc;   // 0 none, 1 ok, 2 fail
    logic        brk;    // break before request
    logic [1:0]  mode;   // 0 abs, 1 rel, 2 same
    logic [6:0]  bits;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,2'd1,21'h012345,2'd0,32'h0,2'd1,1'b0,2'd0,7'd32},       // R4 invalid
    '{2'd0,1'b0,2'd1,21'h012346,2'd1,32'h0,2'd1,1'b0,2'd2,7'd12},       // R2 R5
    '{2'd0,1'b1,2'd1,21'h012400,2'd2,32'h44332211,2'd1,1'b0,2'd1,7'd52},// R3 R5
    '{2'd0,1'b0,2'd1,21'h012300,2'd0,32'h0,2'd1,1'b0,2'd1,7'd20},       // R3 -256
    '{2'd0,1'b0,2'd1,21'h012400,2'd0,32'h0,2'd1,1'b0,2'd0,7'd32},       // R4 +256
    '{2'd0,1'b0,2'd2,21'h012400,2'd0,32'h0,2'd2,1'b0,2'd0,7'd32},       // R4 other id
    '{2'd0,1'b0,2'd2,21'h012400,2'd0,32'h0,2'd1,1'b0,2'd0,7'd32},       // R8 fail dropped
    '{2'd0,1'b0,2'd2,21'h0124FF,2'd0,32'h0,2'd1,1'b0,2'd1,7'd20},       // R3 +255
    '{2'd1,1'b0,2'd2,21'h0,     2'd0,32'h0,2'd2,1'b0,2'd0,7'd9},        // R6 dpoll
    '{2'd0,1'b0,2'd2,21'h0124FD,2'd0,32'h0,2'd1,1'b0,2'd2,7'd12},       // R8 poll ignored
    '{2'd3,1'b0,2'd2,21'h0,     2'd0,32'h0,2'd1,1'b0,2'd0,7'd12},       // R6 term
    '{2'd0,1'b0,2'd2,21'h0124FD,2'd0,32'h0,2'd1,1'b0,2'd0,7'd32},       // R8 term dropped
    '{2'd2,1'b0,2'd3,21'h0,     2'd0,32'h0,2'd0,1'b0,2'd0,7'd9},        // R6 epoll
    '{2'd0,1'b0,2'd2,21'h0124FD,2'd0,32'h0,2'd1,1'b1,2'd0,7'd32},       // R9 break
    '{2'd0,1'b1,2'd0,21'h1FFFFF,2'd0,32'h000000A5,2'd1,1'b0,2'd0,7'd40} // R5 1-byte write
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_id_i = '0;
  logic [20:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        done_i = 1'b0;
  logic        done_ok_i = 1'b0;
  logic        break_i = 1'b0;
  logic        frame_valid_o;
  logic [63:0] frame_o;
  logic [6:0]  frame_bits_o;

  always #2 clk_i = ~clk_i;

  addr_cmp_frame_enc dut_i (.*);

  int   n_total = 0;
  int   n_fail  = 0;
  bit   finished = 1'b0;
  vec_t v;
  logic [63:0] exp_f;
  int   exp_n;
  // bench copy of the remembered word
  logic        m_valid = 1'b0;
  logic [18:0] m_word  = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] bapp(input logic [63:0] f, input logic [63:0] x, input int w);
    return (f << w) | (x & ((64'd1 << w) - 64'd1));
  endfunction

  // independent frame model; the mode comes from the vector table
  task automatic model(input vec_t s, output logic [63:0] f, output int n);
    logic [20:0] fld;
    logic [3:0]  c;
    int aw, nb;
    f = '0; n = 2;
    f = bapp(f, 64'(s.id), 2);
    case (s.kind)
      2'd0: begin
        case (s.mode)
          2'd2:    begin fld = {19'd0, s.addr[1:0]}; aw = 2; f = bapp(f, 64'h3, 2); n += 2; end
          2'd1:    begin fld = (s.addr - {m_word, 2'b00}) & 21'h1FF; aw = 9;
                         f = bapp(f, 64'h5, 3); n += 3; end
          default: begin fld = s.addr; aw = 21; f = bapp(f, 64'h4, 3); n += 3; end
        endcase
        nb = (s.size == 2'd0) ? 1 : (s.size == 2'd1) ? 2 : 4;
        if (nb == 2) fld[0] = 1'b0;
        if (nb == 4) fld[1:0] = 2'b01;
        f = bapp(f, 64'(!s.wr), 1);
        f = bapp(f, 64'(fld), aw);
        f = bapp(f, 64'(nb > 1), 1);
        n += aw + 2;
        if (s.wr) for (int i = 0; i < nb; i++) begin
          f = bapp(f, 64'(s.wdata[8*i +: 8]), 8); n += 8;
        end
      end
      2'd1:    begin f = bapp(f, 64'h2, 3); n += 3; end
      2'd2:    begin f = bapp(f, 64'h3, 3); n += 3; end
      default: begin f = bapp(f, 64'h3f, 6); n += 6; end
    endcase
    c = 4'h0;
    c = {c[2:0], 1'b0} ^ ({4{c[3] ^ 1'b1}} & 4'h3);
    for (int i = n - 1; i >= 0; i--) c = {c[2:0], 1'b0} ^ ({4{c[3] ^ f[i]}} & 4'h3);
    f = bapp(f, 64'(c), 4);
    n += 4;
  endtask

  task automatic send(input vec_t s);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_kind_i = s.kind; req_write_i = s.wr; req_id_i = s.id;
    req_addr_i = s.addr; req_size_i = s.size; req_wdata_i = s.wdata;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    #400us;
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 R10 reset state
    chk("R10 reset valid", 64'(frame_valid_o), 64'd0);
    chk("R9 reset bits", 64'(frame_bits_o), 64'd0);
    rst_ni = 1'b1;
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      if (v.brk) begin
        @(negedge clk_i) break_i = 1'b1;
        @(negedge clk_i) break_i = 1'b0;
        m_valid = 1'b0;
      end
      model(v, exp_f, exp_n);
      send(v);
      chk($sformatf("R10 vec%0d valid", k), 64'(frame_valid_o), 64'd1);
      chk($sformatf("R1/R2/R3/R4/R5/R6/R7 vec%0d frame", k), frame_o, exp_f);
      chk($sformatf("R1/R8/R9 vec%0d bits", k), 64'(frame_bits_o), 64'(v.bits));
      if (k == 0) begin
        @(negedge clk_i);
        chk("R10 single pulse", 64'(frame_valid_o), 64'd0);
      end
      if (v.outc != 2'd0) begin
        done_i = 1'b1; done_ok_i = (v.outc == 2'd1);
        @(negedge clk_i);
        done_i = 1'b0; done_ok_i = 1'b0;
        if (v.kind == 2'd0) begin
          m_valid = (v.outc == 2'd1);
          if (v.outc == 2'd1) m_word = v.addr[20:2];
        end else if (v.kind == 2'd3) m_valid = 1'b0;
      end
    end

    // R2 then R9: same request before and after a mid-run reset
    v = VECS[14];
    v.wr = 1'b0; v.mode = 2'd2; v.bits = 7'd12; v.outc = 2'd0;
    model(v, exp_f, exp_n);
    send(v);
    chk("R2 repeat same", frame_o, exp_f);
    chk("R2 repeat bits", 64'(frame_bits_o), 64'd12);
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    m_valid = 1'b0;
    v.mode = 2'd0; v.bits = 7'd32;
    model(v, exp_f, exp_n);
    send(v);
    chk("R9 after reset frame", frame_o, exp_f);
    chk("R9 after reset bits", 64'(frame_bits_o), 64'd32);
    report();
  end
endmodule